// File: doc/BRIEF.md
# FM0/NRZ Receive Bit Synchronizer

This block takes the raw receive line of a bit-oriented serial port and recovers the bit stream. A programmable prescaler turns the system clock into a tick at sixteen times the bit rate. A four-bit phase counter advances on each tick. Every line transition is a chance to pull that counter back to the start of a bit, and when no transition comes the counter wraps at sixteen by itself, so the bit clock keeps running through long quiet stretches.

There are two line codings. In NRZ the line is sampled in the middle of each bit period. In FM0 every bit starts with a transition, and a zero has a second transition in its middle. The synchronizer first aligns itself on a pair of boundary transitions one full bit apart, which the run of ones in a frame flag provides. After that it ignores transitions that come early in a bit, counts them as mid-bit marks, and emits one decoded bit at each boundary. Flag detection, zero-bit removal and the frame check are done further downstream.

Top module: `rx_bitsync`

## Requirements
- R1: With divisor field value N (0 to 4095), the oversample tick comes every N+1 clock cycles, so bit strobes arrive 16*(N+1) cycles apart while the line stays quiet.
- R2: While rst_n is low, bit_valid and bit_out are both 0.
- R3: In NRZ mode (mode_fm0 = 0) a bit is sampled when the phase counter reaches 8 counted from the last boundary, and the recovered value equals the line level in that bit period.
- R4: Any line transition in NRZ mode restarts the phase counter. Without transitions the counter wraps every 16 ticks, so a run of equal bits yields one strobe per bit period.
- R5: In FM0 mode (mode_fm0 = 1) a bit period with a transition inside it decodes as 0 and one without decodes as 1. Each bit is emitted at the boundary that ends it.
- R6: In FM0 mode, once aligned, a transition that arrives while the phase counter is below 12 does not restart the phase. It only marks the current bit as a zero.
- R7: After reset, FM0 mode emits nothing until two transitions have arrived 12 to 16 ticks apart with no wrap between them. For a line that starts with the flag 0,1,1,1,1,1,1,0, the first emitted bit is the flag's third bit.
- R8: bit_valid is a single-cycle pulse that only follows an oversample tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_val | input | 12 | Prescaler field N; divide by N+1 |
| mode_fm0 | input | 1 | 1 = FM0 decoding, 0 = NRZ sampling |
| rx_line | input | 1 | Asynchronous receive line, idle high |
| bit_out | output | 1 | Recovered bit value |
| bit_valid | output | 1 | One-cycle strobe qualifying bit_out |

## Verification
The bench drives NRZ streams that contain runs of twenty ones and sixteen zeros. A design without a working flywheel would drop bits in those runs, and one that sampled away from mid-bit would return shifted or flipped values once the divisor is at its smallest. FM0 streams full of zeros test the mid-bit mask: a design that let those transitions restart the phase would lose bits or invert them. Starting with an FM0 flag tests alignment, because an early or wrong lock shows up as extra or missing leading bits. A sweep of divisor values, including 0 and 255, checks the strobe spacing for an off-by-one in the prescaler.

// File: rtl/rx_bitsync_pkg.sv
package rx_bitsync_pkg;

  typedef enum logic {
    CODE_NRZ = 1'b0,
    CODE_FM0 = 1'b1
  } line_code_e;

  // Phase has reached or passed a marker position within the bit.
  function automatic bit at_or_past(int unsigned ph, int unsigned mark);
    return ph >= mark;
  endfunction

  // Clock cycles in one bit for a given divisor field and oversample ratio.
  function automatic int unsigned bit_cycles(int unsigned div_field, int unsigned os);
    return (div_field + 1) * os;
  endfunction

endpackage

// File: rtl/rx_os_prescale.sv
module rx_os_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             os_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             hit;

  // The >= compare keeps a divisor lowered on the fly from a long wrap.
  assign hit     = (cnt_q >= div_val);
  assign os_tick = hit;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic line_s,
  output logic line_edge
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
      prev_q <= IDLE;
    end else begin
      meta_q <= rx_line;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_s    = sync_q;
  assign line_edge = sync_q ^ prev_q;
endmodule

// File: rtl/rx_phase_track.sv
module rx_phase_track
  import rx_bitsync_pkg::*;
#(
  parameter int OS     = 16,
  parameter int PH_W   = $clog2(OS),
  parameter int SAMPLE = 8,
  parameter int GUARD  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            os_tick,
  input  logic            line_s,
  input  logic            line_edge,
  input  line_code_e      code,
  output logic [PH_W-1:0] ph_cnt,
  output logic            locked,
  output logic            bit_out,
  output logic            bit_valid
);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(OS - 1);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SAMPLE);

  logic edge_hold_q, evt, wrap, guard_ok;
  logic armed_q, mid_seen_q;

  // An edge that lands between ticks is held until the next tick uses it.
  assign evt      = line_edge | edge_hold_q;
  assign wrap     = (ph_cnt == PH_LAST);
  assign guard_ok = at_or_past(int'(ph_cnt), GUARD);

  always_ff @(posedge clk) begin
    if (!rst_n) edge_hold_q <= 1'b0;
    else        edge_hold_q <= os_tick ? 1'b0 : evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_cnt     <= '0;
      locked     <= 1'b0;
      armed_q    <= 1'b0;
      mid_seen_q <= 1'b0;
      bit_out    <= 1'b0;
      bit_valid  <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (os_tick) begin
        if (code == CODE_NRZ) begin
          locked     <= 1'b0;
          armed_q    <= 1'b0;
          mid_seen_q <= 1'b0;
          ph_cnt     <= evt ? '0 : ph_cnt + 1'b1;
          if (ph_cnt == PH_SAMPLE) begin
            bit_out   <= line_s;
            bit_valid <= 1'b1;
          end
        end else if (!locked) begin
          if (evt) begin
            ph_cnt     <= '0;
            mid_seen_q <= 1'b0;
            if (armed_q && guard_ok) locked  <= 1'b1;
            else                     armed_q <= 1'b1;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
            if (wrap) armed_q <= 1'b0;
          end
        end else if ((evt && guard_ok) || (!evt && wrap)) begin
          // Bit boundary: a late transition or a flywheel wrap.
          ph_cnt     <= '0;
          bit_out    <= ~mid_seen_q;
          bit_valid  <= 1'b1;
          mid_seen_q <= 1'b0;
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
          if (evt) mid_seen_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_bitsync.sv
module rx_bitsync
  import rx_bitsync_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int OS     = 16,
  parameter int SAMPLE = 8,
  parameter int GUARD  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             mode_fm0,
  input  logic             rx_line,
  output logic             bit_out,
  output logic             bit_valid
);
  localparam int PH_W = $clog2(OS);

  logic            os_tick;
  logic            line_s;
  logic            line_edge;
  logic [PH_W-1:0] ph_cnt;
  logic            locked;
  line_code_e      code;

  assign code = line_code_e'(mode_fm0);

  rx_os_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .os_tick(os_tick)
  );

  rx_line_sync #(.IDLE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .line_s(line_s), .line_edge(line_edge)
  );

  rx_phase_track #(.OS(OS), .PH_W(PH_W), .SAMPLE(SAMPLE), .GUARD(GUARD)) u_phase (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_s(line_s),
    .line_edge(line_edge), .code(code), .ph_cnt(ph_cnt), .locked(locked),
    .bit_out(bit_out), .bit_valid(bit_valid)
  );
endmodule

// File: rtl/rx_bitsync_chk.sv
module rx_bitsync_chk #(
  parameter int DIV_W  = 12,
  parameter int PH_W   = 4,
  parameter int SAMPLE = 8,
  parameter int GUARD  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_val,
  input logic             mode_fm0,
  input logic             os_tick,
  input logic             line_s,
  input logic [PH_W-1:0]  ph_cnt,
  input logic             locked,
  input logic             bit_out,
  input logic             bit_valid
);
  localparam logic [PH_W-1:0] PS = PH_W'(SAMPLE);
  localparam logic [PH_W-1:0] PG = PH_W'(GUARD);

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && div_val != '0) |=> !os_tick);

  assert_nrz_midpoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !mode_fm0) |-> ($past(ph_cnt) == PS));

  assert_nrz_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !mode_fm0) |-> (bit_out == $past(line_s)));

  assert_fm0_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && mode_fm0) |-> ($past(ph_cnt) >= PG));

  assert_fm0_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && mode_fm0) |-> locked);

  assert_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(os_tick));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
endmodule

bind rx_bitsync rx_bitsync_chk #(
  .DIV_W(DIV_W), .PH_W(PH_W), .SAMPLE(SAMPLE), .GUARD(GUARD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .div_val(div_val), .mode_fm0(mode_fm0),
  .os_tick(os_tick), .line_s(line_s), .ph_cnt(ph_cnt), .locked(locked),
  .bit_out(bit_out), .bit_valid(bit_valid)
);

// File: tb/rx_bitsync_tb_top.sv
`timescale 1ns/1ps
module rx_bitsync_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div_val = '0;
  logic        mode_fm0 = 1'b0;
  logic        rx_line = 1'b1;
  logic        bit_out, bit_valid;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit rec_en = 1'b0;
  bit prev_v = 1'b0;
  int rx_n = 0;
  logic rx_bits [0:511];
  int   rx_time [0:511];
  logic pat [0:63];
  logic fm_seq [0:55];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_bitsync dut_i (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .mode_fm0(mode_fm0),
    .rx_line(rx_line), .bit_out(bit_out), .bit_valid(bit_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Collector: a pulse must never last two cycles (R8).
  always @(negedge clk) begin
    if (rec_en && bit_valid) begin
      if (rx_n < 512) begin
        rx_bits[rx_n] = bit_out;
        rx_time[rx_n] = cyc;
        rx_n++;
      end
      chk(!prev_v, "R8 pulse width", 2, 1);
    end
    prev_v = bit_valid;
  end

  task automatic do_reset(input int d, input bit fm0);
    @(negedge clk);
    rec_en = 1'b0; rst_n = 1'b0; div_val = 12'(d); mode_fm0 = fm0; rx_line = 1'b1;
    repeat (4) @(negedge clk);
    chk(bit_valid == 1'b0, "R2 valid in reset", int'(bit_valid), 0);
    chk(bit_out == 1'b0, "R2 data in reset", int'(bit_out), 0);
    rx_n = 0; prev_v = 1'b0; rec_en = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic run_interval(input int d);
    int p;
    p = 16 * (d + 1);
    do_reset(d, 1'b0);
    while (rx_n < 4) @(negedge clk);
    chk(rx_time[2] - rx_time[1] == p, "R1 strobe spacing", rx_time[2] - rx_time[1], p);
    chk(rx_time[3] - rx_time[2] == p, "R1 strobe spacing", rx_time[3] - rx_time[2], p);
  endtask

  task automatic run_nrz(input int d);
    int p, f;
    p = 16 * (d + 1);
    do_reset(d, 1'b0);
    repeat (3 * p) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      rx_line = pat[i];
      repeat (p) @(negedge clk);
    end
    repeat (3 * p) @(negedge clk);
    f = -1;
    for (int i = 0; i < rx_n; i++) if (f < 0 && rx_bits[i] == 1'b0) f = i;
    chk(f >= 0 && f + 64 <= rx_n, "R4 strobe count", rx_n - f, 64);
    if (f >= 0) begin
      for (int i = 0; i < 64; i++) begin
        if (f + i < rx_n) begin
          // Bits 20..55 are long runs carried by the flywheel (R4).
          if (i >= 20 && i < 56)
            chk(rx_bits[f+i] == pat[i], "R4 run bit", int'(rx_bits[f+i]), int'(pat[i]));
          else
            chk(rx_bits[f+i] == pat[i], "R3 nrz bit", int'(rx_bits[f+i]), int'(pat[i]));
        end
      end
    end
  endtask

  task automatic run_fm0(input int d);
    int p, h;
    p = 16 * (d + 1);
    h = p / 2;
    do_reset(d, 1'b1);
    repeat (3 * p) @(negedge clk);
    for (int i = 0; i < 56; i++) begin
      rx_line = ~rx_line;
      repeat (h) @(negedge clk);
      if (fm_seq[i] == 1'b0) rx_line = ~rx_line;
      repeat (p - h) @(negedge clk);
    end
    rx_line = ~rx_line;
    repeat (2 * p) @(negedge clk);
    // Alignment consumes the first two flag bits (R7).
    chk(rx_n >= 54, "R7 emitted count", rx_n, 54);
    if (rx_n > 0)
      chk(rx_bits[0] == fm_seq[2], "R7 first bit", int'(rx_bits[0]), int'(fm_seq[2]));
    for (int i = 0; i < 54; i++) begin
      if (i < rx_n) begin
        if (fm_seq[i+2] == 1'b0)
          chk(rx_bits[i] == 1'b0, "R6 masked zero", int'(rx_bits[i]), 0);
        else
          chk(rx_bits[i] == 1'b1, "R5 fm0 one", int'(rx_bits[i]), 1);
      end
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    report();
    $finish;
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      pat[i] = lf[0];
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end
    pat[0] = 1'b0;
    for (int i = 20; i < 40; i++) pat[i] = 1'b1;
    for (int i = 40; i < 56; i++) pat[i] = 1'b0;
    for (int i = 0; i < 8; i++) fm_seq[i] = (i != 0 && i != 7);
    for (int i = 0; i < 48; i++) fm_seq[8+i] = pat[i];

    run_interval(0);
    run_interval(1);
    run_interval(2);
    run_interval(7);
    run_interval(255);
    run_nrz(0);
    run_nrz(1);
    run_nrz(3);
    run_fm0(0);
    run_fm0(2);
    report();
    $finish;
  end
endmodule